// File: doc/BRIEF.md
# Autonomous Sensor Measurement Sequencer

This block takes routine sensor sampling off the host processor. Once it is enabled, an internal period timer fires at a programmed interval. On each firing the sequencer switches the external sensor on and lets it settle for a programmed number of cycles. It then pulses a start request to an external ADC and waits for the converter's done strobe. At that point it captures the converter result and switches the sensor off again.

The captured value is compared with the previously stored sample. The CPU interrupt is raised only when the value has moved, so the processor can sleep through measurements that carry no news. The sequencer therefore works as an event filter. Packet building and protocol work remain with the CPU.

A converter that never answers is handled by a programmable timeout. The timeout aborts the measurement, powers the sensor down and raises a sticky error flag. Configuration is written through a small address/data write port.

Top module: `meas_sequencer`

## Requirements
- R1: The write port decodes four word addresses. Address 0 holds the period P, and a tick fires every P cycles (0 acts as 1). Address 1 holds the settle count S. Address 2 holds the timeout T. Address 3 is control: bit 0 is enable (stored), a 1 in bit 1 clears the interrupt, and a 1 in bit 2 clears the error flag. While enable is 0, no measurement starts and `sensorPwr` stays low.
- R2: Each measurement raises `sensorPwr` and holds it high for exactly S cycles before the cycle in which `adcStart` is high. With S = 0, `adcStart` and `sensorPwr` rise in the same cycle.
- R3: `adcStart` is a single-cycle pulse, issued once per measurement, with `sensorPwr` high.
- R4: An `adcDone` seen while waiting captures `adcData` in that cycle, and `sensorPwr` is low from the next cycle on.
- R5: After a capture, `sampleOut` shows the captured value. `irq` is set only when that value differs from the previously stored sample.
- R6: The first sample captured after reset always sets `irq`, even when its value equals the reset content (zero) of `sampleOut`.
- R7: `irq` is sticky until a clear write. When a clear write and an interrupt-setting capture fall in the same cycle, `irq` ends up set.
- R8: If `adcDone` does not arrive within T+1 waiting cycles, the measurement is aborted. `sensorPwr` falls and `errFlag` is set, while `sampleOut` and `irq` keep their values. `errFlag` is sticky until a clear write, and an abort in the same cycle as that clear leaves it set.
- R9: Period ticks that occur while a measurement is in progress are ignored. Measurements never overlap or restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration word address |
| cfgWdata | input | CNT_W | Configuration write data |
| adcDone | input | 1 | Converter done strobe |
| adcData | input | DATA_W | Converter result |
| sensorPwr | output | 1 | Sensor power enable |
| adcStart | output | 1 | Converter start pulse |
| irq | output | 1 | Sticky CPU wake-up interrupt |
| errFlag | output | 1 | Sticky converter-timeout error |
| sampleOut | output | DATA_W | Latest stored sample |

## Verification
Two pairs of events can collide. A clear write to the interrupt can coincide with a capture that changes the value, and a clear write to the error flag can coincide with a timeout abort. The bench provokes both by driving the write and the done strobe at the same falling edge, or by timing the error-clear write into the last waiting cycle. It then checks that the flag still reads set on the following cycle, so the new event is never lost.

// File: rtl/meas_seq_pkg.sv
package meas_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_START,
    ST_WAIT
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic abort;
  } seqStrobe_t;

  localparam logic [1:0] ADDR_PERIOD  = 2'd0;
  localparam logic [1:0] ADDR_SETTLE  = 2'd1;
  localparam logic [1:0] ADDR_TIMEOUT = 2'd2;
  localparam logic [1:0] ADDR_CTRL    = 2'd3;
endpackage

// File: rtl/meas_seq_ctrl.sv
module meas_seq_ctrl
  import meas_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periodTick,
  input  logic [CNT_W-1:0] settleCfg,
  input  logic [CNT_W-1:0] timeoutCfg,
  input  logic             adcDone,
  output seqStrobe_t       strobe,
  output logic             sensorPwr,
  output logic             adcStart
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (periodTick) begin
            if (settleCfg == '0) begin
              state <= ST_START;
            end else begin
              state <= ST_SETTLE;
              cnt   <= settleCfg - ONE;
            end
          end
        end
        ST_SETTLE: begin
          if (cnt == '0) state <= ST_START;
          else           cnt   <= cnt - ONE;
        end
        ST_START: begin
          state <= ST_WAIT;
          cnt   <= timeoutCfg;
        end
        ST_WAIT: begin
          if (adcDone || cnt == '0) state <= ST_IDLE;
          else                      cnt   <= cnt - ONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture = (state == ST_WAIT) && adcDone;
    strobe.abort   = (state == ST_WAIT) && !adcDone && (cnt == '0);
    sensorPwr      = (state != ST_IDLE);
    adcStart       = (state == ST_START);
  end

  // R3: start is one cycle wide and the sensor stays powered across it
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> (!adcStart && sensorPwr));

  // R4: power drops right after a capture
  a_r4_pwr_off_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !sensorPwr);

  // R8: power drops right after an abort
  a_r8_pwr_off_after_abort: assert property (@(posedge clk) disable iff (!rstN)
    strobe.abort |=> !sensorPwr);

  // R9: a tick during a running measurement does not bring back a start
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (periodTick && state == ST_WAIT && !adcDone && cnt != '0) |=> !adcStart);
endmodule

// File: rtl/meas_seq_datapath.sv
module meas_seq_datapath
  import meas_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [CNT_W-1:0]  cfgWdata,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] adcData,
  output logic              periodTick,
  output logic [CNT_W-1:0]  settleCfg,
  output logic [CNT_W-1:0]  timeoutCfg,
  output logic              irq,
  output logic              errFlag,
  output logic [DATA_W-1:0] sampleOut
);
  logic [CNT_W-1:0] periodCfg;
  logic [CNT_W-1:0] periodCnt;
  logic [CNT_W:0]   nextCnt;
  logic             enable;
  logic             haveSample;
  logic             ctrlWrite;
  logic             clrIrq;
  logic             clrErr;
  logic             changed;

  always_comb begin
    ctrlWrite  = cfgWe && (cfgAddr == ADDR_CTRL);
    clrIrq     = ctrlWrite && cfgWdata[1];
    clrErr     = ctrlWrite && cfgWdata[2];
    nextCnt    = {1'b0, periodCnt} + {{CNT_W{1'b0}}, 1'b1};
    periodTick = enable && (nextCnt >= {1'b0, periodCfg});
    changed    = !haveSample || (adcData != sampleOut);
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCfg  <= '0;
      settleCfg  <= '0;
      timeoutCfg <= '0;
      enable     <= 1'b0;
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_PERIOD:  periodCfg  <= cfgWdata;
        ADDR_SETTLE:  settleCfg  <= cfgWdata;
        ADDR_TIMEOUT: timeoutCfg <= cfgWdata;
        default:      enable     <= cfgWdata[0];
      endcase
    end
  end

  // period timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    periodCnt <= '0;
    else if (!enable || periodTick) periodCnt <= '0;
    else                          periodCnt <= nextCnt[CNT_W-1:0];
  end

  // sample store and change filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleOut  <= '0;
      haveSample <= 1'b0;
    end else if (strobe.capture) begin
      sampleOut  <= adcData;
      haveSample <= 1'b1;
    end
  end

  // sticky flags: a new event wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq     <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (strobe.capture && changed) irq <= 1'b1;
      else if (clrIrq)               irq <= 1'b0;
      if (strobe.abort)              errFlag <= 1'b1;
      else if (clrErr)               errFlag <= 1'b0;
    end
  end

  a_r6_first_sample_irq: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !haveSample) |=> irq);

  a_r5_sample_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (sampleOut == $past(adcData)));

  a_r5_same_value_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && haveSample && adcData == sampleOut && !irq) |=> !irq);

  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clrIrq) |=> irq);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clrErr) |=> errFlag);

  a_r8_abort_sets_err: assert property (@(posedge clk) disable iff (!rstN)
    strobe.abort |=> (errFlag && $stable(sampleOut)));

  a_r1_no_tick_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !periodTick);
endmodule

// File: rtl/meas_sequencer.sv
module meas_sequencer
  import meas_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [CNT_W-1:0]  cfgWdata,
  input  logic              adcDone,
  input  logic [DATA_W-1:0] adcData,
  output logic              sensorPwr,
  output logic              adcStart,
  output logic              irq,
  output logic              errFlag,
  output logic [DATA_W-1:0] sampleOut
);
  seqStrobe_t       strobe;
  logic             periodTick;
  logic [CNT_W-1:0] settleCfg;
  logic [CNT_W-1:0] timeoutCfg;

  meas_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .periodTick (periodTick),
    .settleCfg  (settleCfg),
    .timeoutCfg (timeoutCfg),
    .adcDone    (adcDone),
    .strobe     (strobe),
    .sensorPwr  (sensorPwr),
    .adcStart   (adcStart)
  );

  meas_seq_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgAddr    (cfgAddr),
    .cfgWdata   (cfgWdata),
    .strobe     (strobe),
    .adcData    (adcData),
    .periodTick (periodTick),
    .settleCfg  (settleCfg),
    .timeoutCfg (timeoutCfg),
    .irq        (irq),
    .errFlag    (errFlag),
    .sampleOut  (sampleOut)
  );
endmodule

// File: tb/tb_meas_sequencer.sv
module tb_meas_sequencer;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [1:0]        cfgAddr = '0;
  logic [CNT_W-1:0]  cfgWdata = '0;
  logic              adcDone = 1'b0;
  logic [DATA_W-1:0] adcData = '0;
  logic              sensorPwr, adcStart, irq, errFlag;
  logic [DATA_W-1:0] sampleOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  meas_sequencer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .adcDone(adcDone), .adcData(adcData), .sensorPwr(sensorPwr), .adcStart(adcStart),
    .irq(irq), .errFlag(errFlag), .sampleOut(sampleOut)
  );

  always #2 clk = ~clk;  // 250 MHz

  // vector: {data[11:0], latency[7:0], expected irq[3:0]}
  localparam logic [23:0] VEC [0:6] = '{
    {12'h000, 8'd1, 4'd1},   // R6 first sample equal to reset content
    {12'h000, 8'd3, 4'd0},
    {12'hABC, 8'd2, 4'd1},
    {12'hABC, 8'd1, 4'd0},
    {12'h001, 8'd5, 4'd1},
    {12'hFFF, 8'd4, 4'd1},
    {12'hFFF, 8'd2, 4'd0}
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // wait until power rises, return cycles of power before adcStart (sampled at negedges)
  task automatic wait_start(output int settleSeen);
    settleSeen = 0;
    @(negedge clk);
    while (!sensorPwr) @(negedge clk);
    while (!adcStart) begin
      settleSeen++;
      @(negedge clk);
    end
  endtask

  // drive done after lat waiting cycles, counting power-high cycles and extra starts
  task automatic finish_conv(input logic [DATA_W-1:0] d, input int lat,
                             output int waitSeen, output int extraStarts);
    waitSeen = 0; extraStarts = 0;
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      if (sensorPwr) waitSeen++;
      if (adcStart) extraStarts++;
    end
    adcData = d; adcDone = 1'b1;
    @(negedge clk);
    adcDone = 1'b0;
  endtask

  initial begin
    int s, w, x, hi;
    logic [DATA_W-1:0] keep;
    repeat (3) @(negedge clk);
    check("R1 reset pwr", sensorPwr, 0);
    check("R7 reset irq", irq, 0);
    check("R8 reset err", errFlag, 0);
    check("R5 reset sample", sampleOut, 0);
    rstN = 1'b1;

    // R1: not enabled -> no activity
    cfg_write(2'd0, 16'd5);
    hi = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (sensorPwr) hi++;
    end
    check("R1 disabled no power", hi, 0);

    cfg_write(2'd0, 16'd40);
    cfg_write(2'd1, 16'd3);
    cfg_write(2'd2, 16'd20);
    cfg_write(2'd3, 16'd1);

    // table-driven measurements
    for (int i = 0; i < 7; i++) begin
      wait_start(s);
      check("R2 settle cycles", s, 3);
      finish_conv(VEC[i][23:12], int'(VEC[i][11:4]), w, x);
      check("R3 single start", x, 0);
      check("R4 power off after capture", sensorPwr, 0);
      check("R5/R6 irq", irq, VEC[i][3:0] != 0);
      check("R5 sample", sampleOut, VEC[i][23:12]);
      check("R8 no error", errFlag, 0);
      if (irq) begin
        cfg_write(2'd3, 16'd3);
        check("R7 clear irq", irq, 0);
      end
    end

    // R2: settle zero
    cfg_write(2'd1, 16'd0);
    wait_start(s);
    check("R2 settle zero", s, 0);
    finish_conv(12'h5A5, 2, w, x);
    check("R5 changed sets irq", irq, 1);
    cfg_write(2'd3, 16'd3);

    // R9: ticks faster than a measurement are ignored
    cfg_write(2'd3, 16'd0);
    cfg_write(2'd0, 16'd3);
    cfg_write(2'd1, 16'd6);
    cfg_write(2'd3, 16'd1);
    wait_start(s);
    finish_conv(12'h5A5, 4, w, x);
    check("R9 settle uninterrupted", s, 6);
    check("R9 no restart start", x, 0);
    check("R9 power continuous in wait", w, 4);
    check("R5 same value no irq", irq, 0);

    // R8: timeout abort
    cfg_write(2'd3, 16'd0);
    cfg_write(2'd0, 16'd40);
    cfg_write(2'd1, 16'd2);
    cfg_write(2'd2, 16'd5);
    cfg_write(2'd3, 16'd1);
    keep = sampleOut;
    wait_start(s);
    hi = 0;
    @(negedge clk);
    while (sensorPwr) begin
      hi++;
      @(negedge clk);
    end
    check("R8 wait cycles before abort", hi, 6);
    check("R8 error set", errFlag, 1);
    check("R8 sample kept", sampleOut, keep);
    check("R8 irq kept", irq, 0);
    cfg_write(2'd3, 16'd5);
    check("R8 error cleared", errFlag, 0);

    // R8: abort and clear in the same cycle
    wait_start(s);
    for (int k = 0; k < 6; k++) @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 2'd3; cfgWdata = 16'd5;
    @(negedge clk);
    cfgWe = 1'b0;
    check("R8 abort wins over clear", errFlag, 1);
    check("R8 power off after abort", sensorPwr, 0);
    cfg_write(2'd3, 16'd5);

    // R7: changed capture and irq clear in the same cycle
    wait_start(s);
    @(negedge clk);
    adcData = 12'h777; adcDone = 1'b1;
    cfgWe = 1'b1; cfgAddr = 2'd3; cfgWdata = 16'd3;
    @(negedge clk);
    adcDone = 1'b0; cfgWe = 1'b0;
    check("R7 set wins over clear", irq, 1);
    check("R5 sample on collision", sampleOut, 12'h777);

    finish_run();
  end
endmodule